// File: doc/BRIEF.md
# Page-Splitting Cycle-Stealing DMA Controller

This block moves a run of bytes between a byte-wide peripheral and memory without processor involvement. Software writes a start address, a direction and a byte count, pushes the page numbers that the transfer will continue into, and then issues a start command. From then on the controller sequences bytes on its own. It asks for the memory bus for each byte and uses it only on cycles the arbiter grants, which are cycles the processor leaves idle. It handshakes with the peripheral on every byte and raises an interrupt once the last byte has moved.

Memory is organised in 256-byte pages, and pages that follow each other logically need not be adjacent in physical memory. When the running address wraps past the last byte of a page and bytes remain, the controller stops using the bus. It pops the next page number from a small chain queue that software fills, then continues at byte zero of that page. A long transfer is therefore performed as a chain of single-page segments.

Top module: `dma_pager`

## Requirements
- R1: After reset, status reads 0 (not busy, not done), and `irq_o`, `bus_req_o` and `per_req_o` are low.
- R2: A start command with a nonzero count makes the block busy. A start command written while busy is ignored: the transfer in flight keeps its address, count and direction.
- R3: `mem_we_o`/`mem_re_o` are asserted only in cycles where `bus_gnt_i` is high. `bus_req_o` stays asserted with a stable `mem_addr_o` until a grant arrives.
- R4: Bytes go to consecutive addresses from the start address, with the address advancing by one after each byte.
- R5: Direction 0 (peripheral to memory): a byte is taken from `per_rdata_i` in a cycle where `per_req_o` and `per_valid_i` are both high, and it is then written to memory.
- R6: Direction 1 (memory to peripheral): each byte is read from memory and presented on `per_wdata_o` with `per_req_o` high until the peripheral raises `per_ready_i`.
- R7: Pages are 256 bytes. When the address wraps to a low byte of 0 and bytes remain, the controller pops a page number P from the chain queue and continues at address P*256. While the queue is empty it waits with `bus_req_o` and `per_req_o` low, and the live address reads with low byte 0.
- R8: The chain queue holds 4 page numbers in push order. A push while it is full is dropped.
- R9: When the last byte completes, busy clears and done and `irq_o` rise. They stay high until an acknowledge command or a new start.
- R10: A start with a count of 0 sets done and `irq_o` at once and makes no bus or peripheral access.
- R11: Register offsets on `reg_off_i`: 0 start address (reads back the live address), 1 direction in bit 0, 2 byte count (reads back the remaining count), 3 command (write bit 0 = start, bit 1 = acknowledge; read bit 0 = busy, bit 1 = done), 4 chain push (page number in the low bits). Other offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_off_i | input | 3 | Register offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational from offset) |
| irq_o | output | 1 | Transfer-complete interrupt |
| bus_req_o | output | 1 | Memory bus request |
| bus_gnt_i | input | 1 | Memory bus grant (processor idle) |
| mem_addr_o | output | 16 | Memory byte address |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, valid in the strobe cycle |
| per_req_o | output | 1 | Peripheral byte request |
| per_ack_o | output | 1 | Peripheral byte accepted/delivered |
| per_valid_i | input | 1 | Peripheral data valid (direction 0) |
| per_ready_i | input | 1 | Peripheral ready to take a byte (direction 1) |
| per_rdata_i | input | 8 | Byte from peripheral |
| per_wdata_o | output | 8 | Byte to peripheral |

## Verification
The assertions assume four things about the environment. The arbiter raises `bus_gnt_i` only while `bus_req_o` is high. Memory read data is valid in the same cycle as the read strobe. Software pushes no more page numbers than the queue can take. The controller is never asked to pop from an empty queue. The bench derives the grant from the request ANDed with a pseudo-random processor-busy bit. It drives `per_valid_i` and `per_ready_i` only while a request is pending, and only in the matching direction. It pushes exactly the pages a transfer needs, except in the deliberate overflow case.

// File: rtl/dma_pager_pkg.sv
package dma_pager_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PER,
    ST_BUS,
    ST_ADV,
    ST_PAGE
  } dma_state_e;

  localparam logic [2:0] OFF_ADDR  = 3'd0;
  localparam logic [2:0] OFF_DIR   = 3'd1;
  localparam logic [2:0] OFF_LEN   = 3'd2;
  localparam logic [2:0] OFF_CMD   = 3'd3;
  localparam logic [2:0] OFF_CHAIN = 3'd4;

  localparam int CMD_START_BIT = 0;
  localparam int CMD_ACK_BIT   = 1;
endpackage

// File: rtl/dma_pager_chain.sv
module dma_pager_chain #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     slot_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             push_ok, pop_ok;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign dout_o  = slot_q[rd_q];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok) slot_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= nxt(wr_q);
      if (pop_ok)  rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  // R8: a push into a full queue leaves the occupancy unchanged
  a_r8_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> (cnt_q == $past(cnt_q)));

  // R7: the engine pops only when a page is available
  a_r7_pop_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/dma_pager_regs.sv
module dma_pager_regs
  import dma_pager_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16,
  parameter int PAGE_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        off_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [ADDR_W-1:0] cur_addr_i,
  input  logic [LEN_W-1:0]  remain_i,
  output logic              start_o,
  output logic              ack_o,
  output logic              dir_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              chain_push_o,
  output logic [PAGE_W-1:0] chain_page_o
);
  logic              dir_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= 1'b0;
      addr_q <= '0;
      len_q  <= '0;
    end else if (we_i) begin
      case (off_i)
        OFF_ADDR: addr_q <= wdata_i[ADDR_W-1:0];
        OFF_DIR:  dir_q  <= wdata_i[0];
        OFF_LEN:  len_q  <= wdata_i[LEN_W-1:0];
        default: ;
      endcase
    end
  end

  assign start_o      = we_i && (off_i == OFF_CMD) && wdata_i[CMD_START_BIT];
  assign ack_o        = we_i && (off_i == OFF_CMD) && wdata_i[CMD_ACK_BIT];
  assign chain_push_o = we_i && (off_i == OFF_CHAIN);
  assign chain_page_o = wdata_i[PAGE_W-1:0];
  assign dir_o        = dir_q;
  assign addr_o       = addr_q;
  assign len_o        = len_q;

  always_comb begin
    rdata_o = '0;
    case (off_i)
      OFF_ADDR: rdata_o[ADDR_W-1:0] = cur_addr_i;
      OFF_DIR:  rdata_o[0]          = dir_q;
      OFF_LEN:  rdata_o[LEN_W-1:0]  = remain_i;
      OFF_CMD:  rdata_o[1:0]        = {done_i, busy_i};
      default: ;
    endcase
  end
endmodule

// File: rtl/dma_pager_engine.sv
module dma_pager_engine
  import dma_pager_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int LEN_W     = 16,
  parameter int PAGE_BITS = 8,
  parameter int BYTE_W    = 8,
  localparam int PAGE_W   = ADDR_W - PAGE_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ack_i,
  input  logic              dir_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              pg_valid_i,
  input  logic [PAGE_W-1:0] pg_i,
  output logic              pg_pop_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic              per_req_o,
  output logic              per_ack_o,
  input  logic              per_valid_i,
  input  logic              per_ready_i,
  input  logic [BYTE_W-1:0] per_rdata_i,
  output logic [BYTE_W-1:0] per_wdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [LEN_W-1:0]  remain_o
);
  dma_state_e        state_q;
  logic              dir_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] buf_q;
  logic              done_q;

  // memory-to-peripheral starts on the bus, peripheral-to-memory on the peripheral
  function automatic dma_state_e first_st(input logic d);
    return d ? ST_BUS : ST_PER;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dir_q   <= 1'b0;
      addr_q  <= '0;
      cnt_q   <= '0;
      buf_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      if (ack_i) done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          dir_q   <= dir_i;
          addr_q  <= addr_i;
          cnt_q   <= len_i;
          done_q  <= (len_i == '0);
          state_q <= (len_i == '0) ? ST_IDLE : first_st(dir_i);
        end
        ST_PER: begin
          if (!dir_q && per_valid_i) begin
            buf_q   <= per_rdata_i;
            state_q <= ST_BUS;
          end else if (dir_q && per_ready_i) begin
            addr_q  <= addr_q + ADDR_W'(1);
            cnt_q   <= cnt_q - LEN_W'(1);
            state_q <= ST_ADV;
          end
        end
        ST_BUS: if (bus_gnt_i) begin
          if (dir_q) begin
            buf_q   <= mem_rdata_i;
            state_q <= ST_PER;
          end else begin
            addr_q  <= addr_q + ADDR_W'(1);
            cnt_q   <= cnt_q - LEN_W'(1);
            state_q <= ST_ADV;
          end
        end
        ST_ADV: begin
          if (cnt_q == '0) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (addr_q[PAGE_BITS-1:0] == '0) begin
            state_q <= ST_PAGE;
          end else begin
            state_q <= first_st(dir_q);
          end
        end
        ST_PAGE: if (pg_valid_i) begin
          addr_q  <= {pg_i, {PAGE_BITS{1'b0}}};
          state_q <= first_st(dir_q);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_req_o   = (state_q == ST_BUS);
  assign mem_we_o    = bus_req_o && bus_gnt_i && !dir_q;
  assign mem_re_o    = bus_req_o && bus_gnt_i && dir_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = buf_q;
  assign per_req_o   = (state_q == ST_PER);
  assign per_ack_o   = per_req_o && (dir_q ? per_ready_i : per_valid_i);
  assign per_wdata_o = buf_q;
  assign pg_pop_o    = (state_q == ST_PAGE) && pg_valid_i;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign remain_o    = cnt_q;

  // R3: an ungranted request is held with the same address
  a_r3_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_gnt_i) |=> (bus_req_o && $stable(mem_addr_o)));

  // R2: a start while busy does not reload the direction
  a_r2_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (dir_q == $past(dir_q)));

  // R7: a popped page resumes at byte zero
  a_r7_page_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PAGE && pg_valid_i) |=> (mem_addr_o[PAGE_BITS-1:0] == '0));

  // R9: done never coexists with an active transfer
  a_r9_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R5/R6: the memory strobes are mutually exclusive across cycles of one byte
  a_r5_one_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);
endmodule

// File: rtl/dma_pager.sv
module dma_pager #(
  parameter int ADDR_W      = 16,
  parameter int LEN_W       = 16,
  parameter int PAGE_BITS   = 8,
  parameter int CHAIN_DEPTH = 4,
  parameter int DATA_W      = 32,
  parameter int BYTE_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_off_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic              per_req_o,
  output logic              per_ack_o,
  input  logic              per_valid_i,
  input  logic              per_ready_i,
  input  logic [BYTE_W-1:0] per_rdata_i,
  output logic [BYTE_W-1:0] per_wdata_o
);
  localparam int PAGE_W = ADDR_W - PAGE_BITS;

  logic              start, ack, cfg_dir, busy, done;
  logic [ADDR_W-1:0] cfg_addr;
  logic [LEN_W-1:0]  cfg_len, remain;
  logic              push, pop, pg_empty, pg_full;
  logic [PAGE_W-1:0] push_pg, head_pg;
  logic              unused_full;

  assign unused_full = pg_full;

  dma_pager_regs #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)
  ) regs_i (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .off_i(reg_off_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .busy_i(busy), .done_i(done), .cur_addr_i(mem_addr_o), .remain_i(remain),
    .start_o(start), .ack_o(ack), .dir_o(cfg_dir), .addr_o(cfg_addr), .len_o(cfg_len),
    .chain_push_o(push), .chain_page_o(push_pg)
  );

  dma_pager_chain #(.W(PAGE_W), .DEPTH(CHAIN_DEPTH)) chain_i (
    .clk_i, .rst_ni,
    .push_i(push), .din_i(push_pg), .pop_i(pop),
    .dout_o(head_pg), .empty_o(pg_empty), .full_o(pg_full)
  );

  dma_pager_engine #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BITS(PAGE_BITS), .BYTE_W(BYTE_W)
  ) engine_i (
    .clk_i, .rst_ni,
    .start_i(start), .ack_i(ack), .dir_i(cfg_dir), .addr_i(cfg_addr), .len_i(cfg_len),
    .pg_valid_i(!pg_empty), .pg_i(head_pg), .pg_pop_o(pop),
    .bus_req_o, .bus_gnt_i, .mem_addr_o, .mem_we_o, .mem_re_o, .mem_wdata_o, .mem_rdata_i,
    .per_req_o, .per_ack_o, .per_valid_i, .per_ready_i, .per_rdata_i, .per_wdata_o,
    .busy_o(busy), .done_o(done), .remain_o(remain)
  );

  assign irq_o = done;
endmodule

// File: tb/dma_pager_tb_top.sv
`timescale 1ns/1ps
module dma_pager_tb_top;
  localparam int NEXP = 600;
  localparam int NVEC = 6;
  // {dir, start, len, page0, page1}
  localparam logic [55:0] VEC [NVEC] = '{
    {8'd0, 16'h0010, 16'd16,  8'h00, 8'h00},
    {8'd1, 16'h0120, 16'd40,  8'h00, 8'h00},
    {8'd0, 16'h00F8, 16'd20,  8'h03, 8'h00},
    {8'd1, 16'h02FC, 16'd264, 8'h01, 8'h00},
    {8'd0, 16'h0000, 16'd256, 8'h00, 8'h00},
    {8'd1, 16'h03FF, 16'd1,   8'h00, 8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        reg_we = 1'b0;
  logic [2:0]  reg_off = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq, bus_req, bus_gnt, mem_we, mem_re, per_req, per_ack;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata, per_wdata;
  logic [7:0]  per_rdata = '0;
  logic        per_valid = 1'b0, per_ready = 1'b0, cpu_busy = 1'b0;

  dma_pager dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_off_i(reg_off), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_o(irq), .bus_req_o(bus_req), .bus_gnt_i(bus_gnt),
    .mem_addr_o(mem_addr), .mem_we_o(mem_we), .mem_re_o(mem_re),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .per_req_o(per_req), .per_ack_o(per_ack), .per_valid_i(per_valid), .per_ready_i(per_ready),
    .per_rdata_i(per_rdata), .per_wdata_o(per_wdata)
  );

  logic [7:0] mem [1024];
  logic [7:0] sink [NEXP];
  int exp_addr [NEXP];
  int pgs [8];
  int n_exp = 0, n_pop = 0, vec_idx = 0;
  logic cur_dir = 1'b0;
  int wcnt = 0, rcnt = 0, aerr = 0, steal_err = 0, pidx = 0, sidx = 0;
  int total = 0, fails = 0, cyc = 0;

  assign bus_gnt   = bus_req && !cpu_busy;
  assign mem_rdata = mem[mem_addr[9:0]];

  function automatic logic [7:0] src_byte(input int v, input int k);
    return 8'((k * 13 + v * 29 + 5) & 255);
  endfunction

  function automatic logic [7:0] pat(input int a);
    return 8'((a & 255) ^ (((a >> 8) & 3) * 83));
  endfunction

  // memory model and per-access checks
  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr[9:0]] = mem_wdata;
      if (wcnt >= n_exp || int'(mem_addr) != exp_addr[wcnt] || mem_wdata != src_byte(vec_idx, wcnt))
        aerr++;
      wcnt++;
    end
    if (mem_re) begin
      if (rcnt >= n_exp || int'(mem_addr) != exp_addr[rcnt]) aerr++;
      rcnt++;
    end
    if ((mem_we || mem_re) && cpu_busy) steal_err++;
  end

  // peripheral and processor-activity model
  logic prev_req = 1'b0, prev_valid = 1'b0, prev_ready = 1'b0;
  logic [7:0]  prev_wdata = '0;
  logic [15:0] lfsr = 16'hACE1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_req && prev_valid) pidx++;
      if (prev_req && prev_ready) begin
        if (sidx < NEXP) sink[sidx] = prev_wdata;
        sidx++;
      end
      lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cpu_busy  = lfsr[0] & lfsr[5];
      per_valid = per_req && !cur_dir && (lfsr[2] | lfsr[7]);
      per_ready = per_req && cur_dir && (lfsr[3] | lfsr[9]);
      per_rdata = src_byte(vec_idx, pidx);
      prev_req  = per_req;
      prev_valid = per_valid;
      prev_ready = per_ready;
      prev_wdata = per_wdata;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      total++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] o, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_off = o; reg_wdata = 32'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] o, output logic [31:0] d);
    reg_off = o;
    #1 d = reg_rdata;
  endtask

  task automatic wait_irq(input int maxc, output bit seen);
    seen = 1'b0;
    for (int k = 0; k < maxc; k++) begin
      if (irq) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  // expected address sequence from start, count and chained pages
  task automatic build(input int start, input int len);
    int a;
    a = start; n_pop = 0; n_exp = len;
    for (int k = 0; k < len; k++) begin
      exp_addr[k] = a & 16'hFFFF;
      a++;
      if (k < len - 1 && (a & 255) == 0) begin
        a = pgs[n_pop] << 8;
        n_pop++;
      end
    end
  endtask

  task automatic prep(input int v, input logic d);
    vec_idx = v; cur_dir = d;
    wcnt = 0; rcnt = 0; aerr = 0; steal_err = 0; pidx = 0; sidx = 0;
    for (int i = 0; i < 1024; i++) mem[i] = d ? pat(i) : 8'hEE;
  endtask

  task automatic start_xfer(input logic d, input int start, input int len);
    wr(3'd0, start);
    wr(3'd1, int'(d));
    wr(3'd2, len);
    wr(3'd3, 1);
  endtask

  initial begin
    logic [31:0] d;
    bit seen;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    rd(3'd3, d);
    chk(d[1:0] == 2'b00, "R1 status", int'(d[1:0]), 0);
    chk(irq == 1'b0, "R1 irq", int'(irq), 0);
    chk(bus_req == 1'b0 && per_req == 1'b0, "R1 requests", int'({bus_req, per_req}), 0);

    // table-driven transfers
    for (int v = 0; v < NVEC; v++) begin
      logic        vd;
      int          vs, vl;
      vd = VEC[v][48];
      vs = int'(VEC[v][47:32]);
      vl = int'(VEC[v][31:16]);
      pgs[0] = int'(VEC[v][15:8]);
      pgs[1] = int'(VEC[v][7:0]);
      build(vs, vl);
      prep(v, vd);
      for (int p = 0; p < n_pop; p++) wr(3'd4, pgs[p]);
      start_xfer(vd, vs, vl);
      wait_irq(20000, seen);
      chk(seen, "R9 irq on completion", int'(seen), 1);
      rd(3'd3, d);
      chk(d[1:0] == 2'b10, "R9 status done", int'(d[1:0]), 2);
      rd(3'd2, d);
      chk(d[15:0] == 16'd0, "R11 remaining count", int'(d[15:0]), 0);
      chk(aerr == 0, (n_pop > 0) ? "R7 chained addresses" : "R4 address order", aerr, 0);
      chk(steal_err == 0, "R3 idle cycles only", steal_err, 0);
      if (!vd) begin
        chk(wcnt == vl, "R5 bytes written", wcnt, vl);
      end else begin
        ok = (rcnt == vl) && (sidx == vl);
        for (int k = 0; k < vl && k < NEXP; k++) if (sink[k] != pat(exp_addr[k])) ok = 1'b0;
        chk(ok, "R6 bytes delivered", sidx, vl);
      end
      wr(3'd3, 2);
      chk(irq == 1'b0, "R9 ack clears irq", int'(irq), 0);
    end

    // R10 zero-length start
    prep(20, 1'b0);
    n_exp = 0;
    start_xfer(1'b0, 16'h0080, 0);
    @(negedge clk);
    chk(irq == 1'b1, "R10 irq at once", int'(irq), 1);
    chk(wcnt + rcnt + pidx == 0, "R10 no access", wcnt + rcnt + pidx, 0);
    wr(3'd3, 2);

    // R2 start while busy
    prep(10, 1'b0);
    build(16'h0040, 8);
    start_xfer(1'b0, 16'h0040, 8);
    rd(3'd3, d);
    chk(d[0] == 1'b1, "R2 busy after start", int'(d[0]), 1);
    wr(3'd2, 3);
    wr(3'd0, 16'h0300);
    wr(3'd3, 1);
    rd(3'd1, d);
    chk(d[0] == 1'b0, "R11 direction readback", int'(d[0]), 0);
    wait_irq(5000, seen);
    chk(seen && wcnt == 8 && aerr == 0, "R2 second start ignored", wcnt, 8);
    wr(3'd3, 2);

    // R8 queue depth and drop, R7 wait on empty queue
    wr(3'd4, 1); wr(3'd4, 2); wr(3'd4, 3); wr(3'd4, 0); wr(3'd4, 1);
    for (int i = 0; i < 4; i++) begin
      pgs[0] = (i == 3) ? 0 : i + 1;
      build(16'h00FF, 2);
      prep(30 + i, 1'b0);
      start_xfer(1'b0, 16'h00FF, 2);
      wait_irq(5000, seen);
      chk(seen && wcnt == 2 && aerr == 0, "R8 queue order", aerr, 0);
      wr(3'd3, 2);
    end
    pgs[0] = 2;
    build(16'h00FF, 2);
    prep(40, 1'b0);
    start_xfer(1'b0, 16'h00FF, 2);
    repeat (60) @(negedge clk);
    rd(3'd3, d);
    chk(d[0] == 1'b1, "R8 overflow push dropped", int'(d[0]), 1);
    chk(bus_req == 1'b0 && per_req == 1'b0, "R7 idle while waiting", int'({bus_req, per_req}), 0);
    rd(3'd0, d);
    chk(d[7:0] == 8'h00, "R7 live address low byte", int'(d[7:0]), 0);
    rd(3'd2, d);
    chk(d[15:0] == 16'd1, "R11 remaining while waiting", int'(d[15:0]), 1);
    wr(3'd4, 2);
    wait_irq(5000, seen);
    chk(seen && wcnt == 2 && aerr == 0, "R7 resumes at new page", aerr, 0);
    wr(3'd3, 2);

    summary();
    $finish;
  end
endmodule